// File: doc/BRIEF.md
# Latching Input Transition Detector

This block watches a group of general-purpose input pins and reports any change of level. It keeps a stored copy of the pins, called the snapshot. It also keeps a sticky change flag for each bit. When any flag is raised, it pulls an active-low interrupt line. It sits beside a two-wire serial slave engine, which sends it a few single-cycle strobes and level qualifiers. The block has no serial protocol logic and no interrupt mask.

The pins first pass through a multi-stage synchronizer. The comparison is then made every clock. The strobes work as follows:

- **Sample strobe.** Given on each acknowledge of an access to the monitored group. It reloads the snapshot and clears the flags. It first copies the old flag byte to an output, so the bus engine can return it as the second read byte.
- **Address-acknowledge strobe.** Releases the interrupt for an access to the monitored group. During a read, the interrupt is held off and raised at STOP if a change happened inside the read.
- **Write-load strobe.** Opens a short blanking window after the block's own pin writes. During the window the snapshot follows the pins, so self-inflicted changes raise no flag.

Top module: `ptd_port_watch`

## Requirements
- R1: After reset the previous-flag output is 0, the interrupt output is high (deasserted), and once the synchronizer has settled the snapshot equals the pins without raising any flag or interrupt.
- R2: Outside a read transaction, a pin that differs from its snapshot bit sets that bit's flag and drives the interrupt output low within four clocks.
- R3: A pin change lasting a single clock still latches its flag and asserts the interrupt.
- R4: A sample strobe with the group select high loads the synchronized pins into the snapshot, clears all flags, and puts the flag value held before clearing on the previous-flag output. Bit n of that output is pin n.
- R5: A sample strobe with the group select low changes neither the snapshot, nor the flags, nor the previous-flag output.
- R6: An address-acknowledge strobe with the group select high deasserts the interrupt on the next clock. With the group select low it leaves the interrupt unchanged.
- R7: After an address acknowledge with the read qualifier high (read = 1), pin changes keep the interrupt deasserted. A STOP strobe then asserts it if any change occurred during that read.
- R8: A STOP strobe that ends a read with no pin change leaves the interrupt deasserted.
- R9: For BLANK_CYC clocks after a write-load strobe with the group select high, no flag is set and the snapshot tracks the pins. After the window, changes are flagged again.
- R10: After an address acknowledge with the read qualifier low (write), a pin change asserts the interrupt without waiting for STOP.
- R11: A flag stays set when its pin returns to the snapshot level. It is cleared only by a sample strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | W | Asynchronous pin levels |
| sample_i | input | 1 | Acknowledge strobe: load snapshot, clear flags |
| addr_ack_i | input | 1 | Slave-address acknowledge strobe |
| stop_i | input | 1 | STOP condition strobe |
| io_sel_i | input | 1 | Current access targets the monitored group |
| rd_i | input | 1 | Current access is a read (1) or write (0) |
| wr_load_i | input | 1 | Strobe when a serial write updates the pin drivers |
| prev_flags_o | output | W | Flag byte captured before the last clear |
| snapshot_o | output | W | Stored snapshot |
| irq_n_o | output | 1 | Latched interrupt, active low |

## Verification
Directed scenarios apply changes of different shapes, each chosen to separate one behaviour from the others:

- **Multi-clock level change.** Distinguishes a latched flag from a level compare.
- **One-clock pulse.** Confirms the flag is sticky rather than sampled.
- **Change that later returns to the original level.** Shows the flag does not clear on its own.

Changes placed inside a read, inside a write, and right after a write-load strobe tell apart the three interrupt timings: deferred to STOP, immediate, and suppressed. Strobes with the group select low prove that the other port group's accesses leave the snapshot, flags and interrupt untouched.

// File: rtl/ptd_pkg.sv
package ptd_pkg;

    // Interrupt controller phases
    typedef enum logic [1:0] {
        IRQ_IDLE     = 2'd0,  // deasserted, outside a read
        IRQ_FIRED    = 2'd1,  // asserted
        IRQ_RD_QUIET = 2'd2,  // inside a read, no change seen
        IRQ_RD_PEND  = 2'd3   // inside a read, change seen, fire at STOP
    } irq_phase_e;

endpackage

// File: rtl/ptd_sync.sv
module ptd_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] sync_o
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] sh_d, sh_q;

        always_comb begin
            sh_d = {sh_q[STAGES-2:0], pin_i[b]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= sh_d;
        end

        assign sync_o[b] = sh_q[STAGES-1];
    end

endmodule

// File: rtl/ptd_track.sv
module ptd_track #(
    parameter int W         = 8,
    parameter int BLANK_CYC = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_i,
    input  logic         sample_i,
    input  logic         wr_load_i,
    input  logic         sample_raw_i,
    input  logic         io_sel_i,
    output logic [W-1:0] snap_o,
    output logic [W-1:0] prev_o,
    output logic         chg_any_o
);

    localparam int CW = $clog2(BLANK_CYC + 1);

    typedef struct packed {
        logic [W-1:0]  snap;
        logic [W-1:0]  flags;
        logic [W-1:0]  prev;
        logic [CW-1:0] blank;
    } trk_t;

    trk_t         st_d, st_q;
    logic [W-1:0] chg_vec;

    always_comb begin
        chg_vec = (st_q.blank == '0) ? (sync_i ^ st_q.snap) : '0;
        st_d    = st_q;

        if (st_q.blank != '0) begin
            st_d.snap  = sync_i;
            st_d.blank = st_q.blank - 1'b1;
        end

        st_d.flags = st_q.flags | chg_vec;

        if (sample_i) begin
            st_d.prev  = st_q.flags | chg_vec;
            st_d.flags = '0;
            st_d.snap  = sync_i;
        end

        if (wr_load_i) begin
            st_d.blank = CW'(BLANK_CYC);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.snap  <= '0;
            st_q.flags <= '0;
            st_q.prev  <= '0;
            st_q.blank <= CW'(BLANK_CYC);
        end else begin
            st_q <= st_d;
        end
    end

    assign snap_o    = st_q.snap;
    assign prev_o    = st_q.prev;
    assign chg_any_o = |chg_vec;

    AST_SAMPLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        sample_i |=> (st_q.flags == '0)); // R4

    AST_NO_FLAG_WHILE_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.blank != '0) |=> ((st_q.flags & ~$past(st_q.flags)) == '0)); // R9

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_i |=> ((st_q.flags & $past(st_q.flags)) == $past(st_q.flags))); // R11

    AST_OTHER_GROUP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_raw_i && !io_sel_i && st_q.blank == '0) |=>
            ($stable(st_q.snap) && $stable(st_q.prev))); // R5

endmodule

// File: rtl/ptd_irq.sv
module ptd_irq
    import ptd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic addr_ack_i,
    input  logic io_sel_i,
    input  logic rd_i,
    input  logic stop_i,
    input  logic chg_any_i,
    output logic irq_n_o
);

    typedef struct packed {
        irq_phase_e ph;
    } irq_t;

    irq_t st_d, st_q;

    always_comb begin
        st_d = st_q;

        unique case (st_q.ph)
            IRQ_IDLE:     if (chg_any_i) st_d.ph = IRQ_FIRED;
            IRQ_FIRED:    st_d.ph = IRQ_FIRED;
            IRQ_RD_QUIET: if (chg_any_i) st_d.ph = IRQ_RD_PEND;
            IRQ_RD_PEND:  st_d.ph = IRQ_RD_PEND;
            default:      st_d.ph = IRQ_IDLE;
        endcase

        if (stop_i) begin
            if (st_q.ph == IRQ_RD_PEND)
                st_d.ph = IRQ_FIRED;
            else if (st_q.ph == IRQ_RD_QUIET)
                st_d.ph = chg_any_i ? IRQ_FIRED : IRQ_IDLE;
        end

        if (addr_ack_i && io_sel_i) begin
            st_d.ph = rd_i ? IRQ_RD_QUIET : IRQ_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.ph <= IRQ_IDLE;
        else        st_q    <= st_d;
    end

    assign irq_n_o = (st_q.ph != IRQ_FIRED);

    AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_ack_i && io_sel_i) |=> irq_n_o); // R6

    AST_READ_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.ph == IRQ_RD_QUIET || st_q.ph == IRQ_RD_PEND) && !stop_i)
            |=> irq_n_o); // R7

    AST_FIRE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n_o) |-> ($past(chg_any_i) || $past(stop_i))); // R2

endmodule

// File: rtl/ptd_port_watch.sv
module ptd_port_watch #(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2,
    parameter int BLANK_CYC   = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins_i,
    input  logic         sample_i,
    input  logic         addr_ack_i,
    input  logic         stop_i,
    input  logic         io_sel_i,
    input  logic         rd_i,
    input  logic         wr_load_i,
    output logic [W-1:0] prev_flags_o,
    output logic [W-1:0] snapshot_o,
    output logic         irq_n_o
);

    logic [W-1:0] pins_sync;
    logic         chg_any;
    logic         sample_en;
    logic         wr_load_en;

    assign sample_en  = sample_i  & io_sel_i;
    assign wr_load_en = wr_load_i & io_sel_i;

    ptd_sync #(
        .W      (W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pins_i),
        .sync_o (pins_sync)
    );

    ptd_track #(
        .W         (W),
        .BLANK_CYC (BLANK_CYC)
    ) u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .sync_i       (pins_sync),
        .sample_i     (sample_en),
        .wr_load_i    (wr_load_en),
        .sample_raw_i (sample_i),
        .io_sel_i     (io_sel_i),
        .snap_o       (snapshot_o),
        .prev_o       (prev_flags_o),
        .chg_any_o    (chg_any)
    );

    ptd_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_ack_i (addr_ack_i),
        .io_sel_i   (io_sel_i),
        .rd_i       (rd_i),
        .stop_i     (stop_i),
        .chg_any_i  (chg_any),
        .irq_n_o    (irq_n_o)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (irq_n_o && prev_flags_o == '0)); // R1

endmodule

// File: tb/ptd_port_watch_bench.sv
module ptd_port_watch_bench;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] pins;
    logic         sample, addr_ack, stop, io_sel, rd, wr_load;
    logic [W-1:0] prev_flags, snapshot;
    logic         irq_n;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    ptd_port_watch #(.W(W), .SYNC_STAGES(2), .BLANK_CYC(4)) u_ptd_port_watch (
        .clk          (clk),
        .rst_n        (rst_n),
        .pins_i       (pins),
        .sample_i     (sample),
        .addr_ack_i   (addr_ack),
        .stop_i       (stop),
        .io_sel_i     (io_sel),
        .rd_i         (rd),
        .wr_load_i    (wr_load),
        .prev_flags_o (prev_flags),
        .snapshot_o   (snapshot),
        .irq_n_o      (irq_n)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // One-clock strobe set, registered at the next posedge, sampled at the negedge after it
    task automatic strobe(input logic aa, input logic smp, input logic stp,
                          input logic io, input logic r, input logic wl);
        addr_ack = aa; sample = smp; stop = stp; io_sel = io; rd = r; wr_load = wl;
        @(negedge clk);
        addr_ack = 0; sample = 0; stop = 0; wr_load = 0;
    endtask

    // Full read of the monitored group: address ack + sample, then STOP
    task automatic io_read(input string req, input logic [W-1:0] exp_prev);
        strobe(1, 1, 0, 1, 1, 0);
        chk(req, {7'd0, irq_n}, 8'd1);
        chk(req, prev_flags, exp_prev);
        chk(req, snapshot, pins);
        strobe(0, 0, 1, 1, 1, 0);
        idle(1);
    endtask

    task automatic t_reset;
        rst_n = 0; pins = 8'hA5;
        sample = 0; addr_ack = 0; stop = 0; io_sel = 0; rd = 0; wr_load = 0;
        idle(3);
        rst_n = 1;
        idle(10);
        chk("R1 prev", prev_flags, 8'h00);
        chk("R1 irq", {7'd0, irq_n}, 8'd1);
        chk("R1 snap", snapshot, 8'hA5);
    endtask

    task automatic t_level_change;
        pins = pins ^ 8'h01;
        idle(5);
        chk("R2 irq", {7'd0, irq_n}, 8'd0);
        io_read("R4 R6 read", 8'h01);
        chk("R8 irq after stop", {7'd0, irq_n}, 8'd1);
    endtask

    task automatic t_pulse;
        pins = pins ^ 8'h08;
        @(negedge clk);
        pins = pins ^ 8'h08;
        idle(5);
        chk("R3 irq", {7'd0, irq_n}, 8'd0);
        io_read("R3 read", 8'h08);
    endtask

    task automatic t_other_group;
        logic [W-1:0] snap0;
        snap0 = snapshot;
        pins = pins ^ 8'h80;
        idle(5);
        chk("R2 irq bit7", {7'd0, irq_n}, 8'd0);
        strobe(1, 1, 0, 0, 0, 0);
        idle(1);
        chk("R6 other group irq", {7'd0, irq_n}, 8'd0);
        chk("R5 snap", snapshot, snap0);
        chk("R5 prev", prev_flags, 8'h08);
        io_read("R5 clear", 8'h80);
    endtask

    task automatic t_read_defer;
        strobe(1, 1, 0, 1, 1, 0);
        pins = pins ^ 8'h04;
        idle(10);
        chk("R7 quiet", {7'd0, irq_n}, 8'd1);
        strobe(0, 1, 0, 1, 1, 0);
        chk("R7 data ack prev", prev_flags, 8'h04);
        chk("R7 still quiet", {7'd0, irq_n}, 8'd1);
        strobe(0, 0, 1, 1, 1, 0);
        chk("R7 fire at stop", {7'd0, irq_n}, 8'd0);
        io_read("R7 clear", 8'h00);
    endtask

    task automatic t_write_path;
        strobe(1, 1, 0, 1, 0, 0);
        chk("R10 released", {7'd0, irq_n}, 8'd1);
        pins = pins ^ 8'h20;
        idle(5);
        chk("R10 immediate", {7'd0, irq_n}, 8'd0);
        strobe(0, 0, 1, 1, 0, 0);
        io_read("R10 clear", 8'h20);
    endtask

    task automatic t_wr_load;
        pins = pins ^ 8'h40;
        strobe(0, 0, 0, 1, 0, 1);
        idle(10);
        chk("R9 no irq", {7'd0, irq_n}, 8'd1);
        chk("R9 snap tracks", snapshot, pins);
        pins = pins ^ 8'h01;
        idle(5);
        chk("R9 after window", {7'd0, irq_n}, 8'd0);
        io_read("R9 clear", 8'h01);
    endtask

    task automatic t_sticky;
        pins = pins ^ 8'h02;
        idle(6);
        pins = pins ^ 8'h02;
        idle(6);
        chk("R11 irq held", {7'd0, irq_n}, 8'd0);
        io_read("R11 prev", 8'h02);
    endtask

    initial begin
        t_reset();
        t_level_change();
        t_pulse();
        t_other_group();
        t_read_defer();
        t_write_path();
        t_wr_load();
        t_sticky();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule